// File: doc/BRIEF.md
# Interrupt Event Latch and Mask Register Set

This block sits between an internal interrupt request and the device's interrupt pin. It holds a single event field in a small memory-mapped register set. A rising edge on the request sets a sticky event latch, and a mask bit decides whether that latch reaches the pin. Software clears the latch by writing a 1. It can read the live request without disturbing anything. It can also set the latch on purpose, to raise a test interrupt.

A global enable input selects between two modes. When the enable is low, which is the state a system comes up in, the block is transparent and the pin follows the request directly. When the enable is high, the latched, masked path drives the pin.

Four 32-bit words are addressed by a 2-bit word index: 0 is the event latch, 1 the mask, 2 the live request state and 3 the force word. These correspond to byte offsets +0, +4, +8 and +12. Only bit 15 of each word is implemented. A write takes effect on bit 15 only when byte enable bit 1 is high. Reads are combinational from the word index.

Top module: `intr_event_gate`

## Requirements
- R1: After reset the event latch and the mask bit are 0; words 0, 1 and 3 read as 0 and the pin is low while the request is low.
- R2: While gate_en is 0, irq_out equals irq_req in the same cycle.
- R3: A 0-to-1 transition of irq_req sets the event latch (word 0, bit 15) at the next clock edge, and the latch stays set after the request falls.
- R4: While gate_en is 1, irq_out is high exactly when both the mask bit and the event latch are 1.
- R5: A write to word 0 with bit 15 = 1 and byte enable bit 1 high clears the event latch; writing 0 to that bit leaves it unchanged.
- R6: If a clearing write to word 0 and a rising edge of irq_req occur in the same cycle, the latch ends up set.
- R7: Word 2, bit 15 reads the current irq_req value, not the latch.
- R8: A write of 1 to bit 15 of word 3 (byte enable bit 1 high) sets the event latch; word 3 always reads 0.
- R9: Word 1, bit 15 is a read/write mask bit; clearing it removes an asserted interrupt while the latch stays set.
- R10: All bits other than 15 read as 0 in every word and ignore writes; a write with byte enable bit 1 low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_en | input | 1 | Global enable; 0 makes the block transparent |
| irq_req | input | 1 | Internal interrupt request, level |
| irq_out | output | 1 | Interrupt to the pin, active high |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_word | input | 2 | Word index: 0 event, 1 mask, 2 state, 3 force |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word |

## Verification
Some properties are checked on every cycle. These are the bypass relation and the rule that a gated pin needs both the mask and the latch. Also checked each cycle: a rising request always leaves the latch set on the next cycle, even against a clearing write, and a lone clearing write does clear it. The read path is checked each cycle too: it keeps every bit other than 15 at zero and mirrors the live request in the state word. The bench scenarios show the sequences that the assertions cannot: that a latch outlives its request, the removal of an interrupt through the mask, the force write, and writes that must change nothing because of the data value or the byte enables.

// File: rtl/intr_event_pkg.sv
// Package: shared parameters and the register word selector for the
// interrupt event gate. Assumes a 32-bit register port with one field.
package intr_event_pkg;

    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int FIELD_BIT = 15;
    localparam int WORD_W    = 2;

    // Word index carried on the register port
    typedef enum logic [WORD_W-1:0] {
        RSEL_EVENT = 2'd0,
        RSEL_MASK  = 2'd1,
        RSEL_STATE = 2'd2,
        RSEL_FORCE = 2'd3
    } rsel_e;

endpackage

// File: rtl/intr_edge_detect.sv
// Module: rising-edge detector for the internal interrupt request.
// Assumes req_i is synchronous to clk. The history flop resets to 0, so a
// request that is already high when reset ends counts as a rising edge.
module intr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);

    logic req_q;

    // Remember the request level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_i;
        end
    end

    assign rise_o = req_i & ~req_q;

endmodule

// File: rtl/intr_event_regs.sv
// Module: event latch and mask storage with write decode.
// Assumes single-cycle write strobes. A set (rising request or force write)
// takes priority over a write-one-to-clear in the same cycle.
module intr_event_regs
    import intr_event_pkg::*;
#(
    parameter int P_DATA_W    = DATA_W,
    parameter int P_FIELD_BIT = FIELD_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  rsel_e               sel_i,
    input  logic [P_DATA_W/8-1:0] be_i,
    input  logic [P_DATA_W-1:0]   wdata_i,
    input  logic                rise_i,
    output logic                evt_o,
    output logic                mask_o
);

    localparam int LANE = P_FIELD_BIT / 8;
    localparam logic [P_DATA_W-1:0]   FIELD_MASK = P_DATA_W'(1) << P_FIELD_BIT;
    localparam logic [P_DATA_W/8-1:0] LANE_MASK  = (P_DATA_W/8)'(1) << LANE;

    logic wbit;
    logic lane_on;
    logic field_wr;
    logic set_evt;
    logic clr_evt;
    logic unused_wdata;
    logic unused_be;

    assign wbit     = wdata_i[P_FIELD_BIT];
    assign lane_on  = be_i[LANE];
    assign field_wr = wr_i & lane_on;

    // Bits outside the field are accepted on the port and discarded
    assign unused_wdata = ^(wdata_i & ~FIELD_MASK);
    assign unused_be    = ^(be_i & ~LANE_MASK);

    // Decode set and clear requests for the event latch
    always_comb begin
        set_evt = rise_i | (field_wr & wbit & (sel_i == RSEL_FORCE));
        clr_evt = field_wr & wbit & (sel_i == RSEL_EVENT);
    end

    // Event latch: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_o <= 1'b0;
        end else if (set_evt) begin
            evt_o <= 1'b1;
        end else if (clr_evt) begin
            evt_o <= 1'b0;
        end
    end

    // Mask bit: plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= 1'b0;
        end else if (field_wr && (sel_i == RSEL_MASK)) begin
            mask_o <= wbit;
        end
    end

endmodule

// File: rtl/intr_read_mux.sv
// Module: read path. Selects the field value of the indexed word and places
// it at the field bit; every other bit of the word is tied to 0.
module intr_read_mux
    import intr_event_pkg::*;
#(
    parameter int P_DATA_W    = DATA_W,
    parameter int P_FIELD_BIT = FIELD_BIT
) (
    input  rsel_e               sel_i,
    input  logic                evt_i,
    input  logic                mask_i,
    input  logic                req_i,
    output logic [P_DATA_W-1:0] rdata_o
);

    logic field;

    // Pick the field value of the addressed word (force reads back 0)
    always_comb begin
        unique case (sel_i)
            RSEL_EVENT: field = evt_i;
            RSEL_MASK:  field = mask_i;
            RSEL_STATE: field = req_i;
            default:    field = 1'b0;
        endcase
    end

    for (genvar i = 0; i < P_DATA_W; i++) begin : g_bit
        if (i == P_FIELD_BIT) begin : g_field
            assign rdata_o[i] = field;
        end else begin : g_zero
            assign rdata_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/intr_event_gate.sv
// Module: top of the interrupt event gate. Latches request edges, masks the
// latch onto irq_out when gate_en is 1, and passes irq_req straight through
// when gate_en is 0. Assumes gate_en is a static-ish configuration level.
module intr_event_gate
    import intr_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_en,
    input  logic              irq_req,
    output logic              irq_out,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_word,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    rsel_e sel;
    logic  rise;
    logic  evt_q;
    logic  mask_q;

    assign sel = rsel_e'(reg_word);

    intr_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (irq_req),
        .rise_o (rise)
    );

    intr_event_regs #(
        .P_DATA_W    (DATA_W),
        .P_FIELD_BIT (FIELD_BIT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .sel_i   (sel),
        .be_i    (reg_be),
        .wdata_i (reg_wdata),
        .rise_i  (rise),
        .evt_o   (evt_q),
        .mask_o  (mask_q)
    );

    intr_read_mux #(
        .P_DATA_W    (DATA_W),
        .P_FIELD_BIT (FIELD_BIT)
    ) u_rd (
        .sel_i   (sel),
        .evt_i   (evt_q),
        .mask_i  (mask_q),
        .req_i   (irq_req),
        .rdata_o (reg_rdata)
    );

    // Pin drive: transparent when disabled, masked latch when enabled
    always_comb begin
        if (gate_en) begin
            irq_out = evt_q & mask_q;
        end else begin
            irq_out = irq_req;
        end
    end

endmodule

// File: rtl/intr_event_gate_checker.sv
// Module: property checker for intr_event_gate, attached with bind.
// Assumes the bound names evt_q, mask_q and rise exist in the top.
module intr_event_gate_checker
    import intr_event_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              gate_en,
    input logic              irq_req,
    input logic              irq_out,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_word,
    input logic [BE_W-1:0]   reg_be,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              evt_q,
    input logic              mask_q,
    input logic              rise
);

    localparam int LANE = FIELD_BIT / 8;

    logic clr_wr;
    logic frc_wr;
    assign clr_wr = reg_wr && reg_word == 2'd0 && reg_be[LANE] && reg_wdata[FIELD_BIT];
    assign frc_wr = reg_wr && reg_word == 2'd3 && reg_be[LANE] && reg_wdata[FIELD_BIT];

    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |-> irq_out == irq_req);

    a_r4_gated_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && irq_out) |-> (mask_q && evt_q));

    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> evt_q);

    a_r6_rise_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && clr_wr) |=> evt_q);

    a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !rise) |=> !evt_q);

    a_r8_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frc_wr |=> evt_q);

    a_r7_state_live: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word == 2'd2) |-> reg_rdata[FIELD_BIT] == irq_req);

    a_r10_other_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(reg_rdata) == (reg_rdata[FIELD_BIT] ? 1 : 0));

endmodule

bind intr_event_gate intr_event_gate_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_en   (gate_en),
    .irq_req   (irq_req),
    .irq_out   (irq_out),
    .reg_wr    (reg_wr),
    .reg_word  (reg_word),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_q     (evt_q),
    .mask_q    (mask_q),
    .rise      (rise)
);

// File: tb/intr_event_gate_bench.sv
// Directed bench for intr_event_gate: one task per scenario.
module intr_event_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] FLD = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gate_en = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_out;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_word = 2'd0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_event_gate u_intr_event_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_en   (gate_en),
        .irq_req   (irq_req),
        .irq_out   (irq_out),
        .reg_wr    (reg_wr),
        .reg_word  (reg_word),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle, started and ended on a falling edge
    task automatic wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = w; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = 32'h0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        reg_word = w;
        #1;
        d = reg_rdata;
    endtask

    // Drop the request and clear any latch
    task automatic tidy();
        @(negedge clk); irq_req = 1'b0;
        wr(2'd0, 4'hF, FLD);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 event after reset", d, 0);
        rd(2'd1, d); check("R1 mask after reset", d, 0);
        rd(2'd3, d); check("R1 force after reset", d, 0);
        rd(2'd2, d); check("R7 state low", d, 0);
        check("R1 pin low", {31'b0, irq_out}, 0);
    endtask

    task automatic t_bypass();
        @(negedge clk); gate_en = 1'b0; irq_req = 1'b1; #1;
        check("R2 bypass high", {31'b0, irq_out}, 1);
        @(negedge clk); irq_req = 1'b0; #1;
        check("R2 bypass low", {31'b0, irq_out}, 0);
        tidy();
    endtask

    task automatic t_latch();
        logic [31:0] d;
        @(negedge clk); irq_req = 1'b1;
        rd(2'd2, d); check("R7 state follows request", d, FLD);
        @(negedge clk); irq_req = 1'b0;
        rd(2'd0, d); check("R3 latch held after fall", d, FLD);
        rd(2'd2, d); check("R7 state drops while latch set", d, 0);
        tidy();
        rd(2'd0, d); check("R5 cleared", d, 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        @(negedge clk); gate_en = 1'b1; irq_req = 1'b1;
        @(negedge clk); irq_req = 1'b0; #1;
        check("R4 masked off", {31'b0, irq_out}, 0);
        wr(2'd1, 4'b0010, FLD);
        rd(2'd1, d); check("R9 mask reads back", d, FLD);
        check("R4 pin asserted", {31'b0, irq_out}, 1);
        wr(2'd1, 4'b0010, 32'h0);
        check("R9 mask clear drops pin", {31'b0, irq_out}, 0);
        rd(2'd0, d); check("R9 latch kept", d, FLD);
        wr(2'd1, 4'b0010, FLD);
        check("R4 pin back", {31'b0, irq_out}, 1);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(2'd0, 4'hF, 32'h0);
        rd(2'd0, d); check("R5 write 0 keeps latch", d, FLD);
        wr(2'd0, 4'hF, FLD);
        rd(2'd0, d); check("R5 w1c clears", d, 0);
        check("R5 pin removed", {31'b0, irq_out}, 0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(2'd3, 4'b0010, FLD);
        rd(2'd0, d); check("R8 force sets latch", d, FLD);
        rd(2'd3, d); check("R8 force reads 0", d, 0);
        check("R8 force raises pin", {31'b0, irq_out}, 1);
        @(negedge clk);
        irq_req = 1'b1;
        reg_wr = 1'b1; reg_word = 2'd0; reg_be = 4'hF; reg_wdata = FLD;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = 32'h0;
        rd(2'd0, d); check("R6 rise wins over clear", d, FLD);
        tidy();
    endtask

    task automatic t_other_bits();
        logic [31:0] d;
        wr(2'd1, 4'hF, 32'h0);
        wr(2'd1, 4'b1101, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R10 lane 1 off leaves mask", d, 0);
        wr(2'd1, 4'hF, 32'hFFFF_7FFF);
        rd(2'd1, d); check("R10 other mask bits ignored", d, 0);
        wr(2'd3, 4'hF, 32'hFFFF_7FFF);
        rd(2'd0, d); check("R10 force other bits ignored", d, 0);
        wr(2'd3, 4'b1101, FLD);
        rd(2'd0, d); check("R10 force lane off ignored", d, 0);
        @(negedge clk); irq_req = 1'b1;
        @(negedge clk);
        wr(2'd0, 4'b1101, FLD);
        rd(2'd0, d); check("R10 clear lane off ignored", d, FLD);
        wr(2'd0, 4'hF, 32'hFFFF_7FFF);
        rd(2'd0, d); check("R10 clear other bits ignored", d, FLD);
        rd(2'd2, d); check("R10 state word only bit 15", d, FLD);
        tidy();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_latch();
        t_mask();
        t_clear();
        t_race();
        t_other_bits();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule